// File: doc/BRIEF.md
# Infrared Raw Pulse-Width Capture Unit

This block watches the demodulated output of an infrared receiver and turns the incoming waveform into a list of symbols. A symbol starts when the line falls. It is measured as two widths: first the time the line stays low, then the time it stays high until the next fall. Widths are counted in units of ten microseconds. The microsecond comes from a programmable prescaler, set to the input clock frequency in MHz minus one. If a high phase runs on until the symbol reaches a programmable maximum width, the stream is taken as finished. The symbol is closed, and a timeout is flagged.

Finished symbols go into a FIFO. A host reads the FIFO through a small word-addressed register port. Reading the data register returns the oldest symbol and removes it. The host can read the fill level, enable the unit and start capture, and program the configuration. It can also mask and clear three interrupt sources: receive level reached, timeout, and FIFO overflow. On overflow the stored symbols stay in place for the host to drain. A single interrupt line is raised for any source that is not masked.

Top module: `irc_capture`

## Requirements
- R1: After reset the config register (offset 0x0C) reads 0x3E80_0080. The fill register reads 0, the status register reads 0, and `irq_o` is low.
- R2: The config register reads back every bit written. Its fields are: max symbol width [31:16], format [15:14], receive level [13:8], raw-mode bit 7 and divisor [6:0]. One unit is 10 x (divisor+1) clock cycles.
- R3: No symbol is captured until bit 0 of the enable register (0x00) is 1 and the start register (0x04) has been written. Writing enable to 0 stops capture.
- R4: A symbol begins on a falling edge of `ir_in`. The FIFO word holds the low width in bits [15:0] and the high width in bits [31:16]. A phase lasting N clock cycles between edges counts floor((N-1)/P) units, where P is the unit length in cycles.
- R5: When low width plus high width reaches the max width during the high phase, the symbol is pushed with high = max - low. Status bit 9 (timeout) is set, and the unit waits for the next falling edge.
- R6: The fill register (0x1C) returns the number of stored symbols. Each read of the data register (0x20) returns the oldest symbol and removes it. A read of the data register while the FIFO is empty returns 0 and changes nothing.
- R7: Status bit 8 (receive) is set while the fill level is at least the receive level plus one.
- R8: A symbol completed while the FIFO is full is dropped. The stored symbols are kept, and status bit 10 (overflow) is set.
- R9: Writing 1 to bits 16, 17 and 18 of the clear register (0x18) clears status bits 8, 9 and 10.
- R10: The status register (0x14) shows the raw flags in bits 8 to 10. Bits 24 to 26 hold the same flags ANDed with the inverse of mask register (0x10) bits 8 to 10. `irq_o` is the OR of bits 24 to 26.
- R11: The busy register (0x08) reads 1 while a symbol is being measured, and 0 when the unit waits for a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data register) |
| reg_addr | input | 6 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt, OR of unmasked flags |

## Verification
The bench drives each phase for a whole number of units plus half a unit. A design that is off by one tick, or that counts the edge cycle, returns widths that are one unit too many or too few. Frames end on a long high phase, so the timeout symbol must carry the exact remaining width. A design that pushes the raw high count, or never returns to idle, fails that check or corrupts the next frame. Overflow is driven with two more symbols than the FIFO holds. A design that flushes or overwrites the FIFO returns the wrong first word or the wrong fill level. The receive level and the mask are swept so that a flag firing one symbol early, or a leaky mask, shows up on `irq_o` and in the mirrored status bits.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef struct packed {
    logic [15:0] high;
    logic [15:0] low;
  } sym_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} meas_st_t;

  localparam logic [3:0] A_ENABLE = 4'h0;
  localparam logic [3:0] A_GO     = 4'h1;
  localparam logic [3:0] A_BUSY   = 4'h2;
  localparam logic [3:0] A_CFG    = 4'h3;
  localparam logic [3:0] A_MASK   = 4'h4;
  localparam logic [3:0] A_STAT   = 4'h5;
  localparam logic [3:0] A_CLR    = 4'h6;
  localparam logic [3:0] A_FILL   = 4'h7;
  localparam logic [3:0] A_DATA   = 4'h8;

  localparam logic [31:0] CFG_RESET = 32'h3E80_0080;
endpackage

// File: rtl/irc_unit_timer.sv
module irc_unit_timer #(
  parameter int DIV_W     = 7,
  parameter int SUB_UNITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int SUB_W = $clog2(SUB_UNITS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_UNITS - 1);

  logic [DIV_W-1:0] cyc_q, cyc_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             us_end;

  always_comb begin
    us_end = (cyc_q >= div_i);
    tick_o = us_end && (sub_q == SUB_LAST);
    cyc_d  = cyc_q;
    sub_d  = sub_q;
    if (restart_i) begin
      cyc_d = '0;
      sub_d = '0;
    end else if (us_end) begin
      cyc_d = '0;
      sub_d = tick_o ? '0 : sub_q + 1'b1;
    end else begin
      cyc_d = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      sub_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      sub_q <= sub_d;
    end
  end
endmodule

// File: rtl/irc_edge_meas.sv
module irc_edge_meas
  import irc_pkg::*;
#(
  parameter int WID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [WID_W-1:0] max_w_i,
  output logic             restart_o,
  output logic             push_o,
  output sym_t             word_o,
  output logic             timeout_o,
  output logic             busy_o
);
  localparam logic [WID_W-1:0] SAT = '1;

  logic [2:0]       sync_q;
  logic             filt_q, prev_q;
  logic             fall, rise;
  meas_st_t         st_q, st_d;
  logic [WID_W-1:0] low_q, low_d, high_q, high_d, high_inc;
  logic [WID_W:0]   sum_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      filt_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[1:0], ir_i};
      if (sync_q[1] == sync_q[2]) filt_q <= sync_q[2];
      prev_q <= filt_q;
    end
  end

  assign fall      = prev_q & ~filt_q;
  assign rise      = ~prev_q & filt_q;
  assign restart_o = fall | rise;
  assign busy_o    = (st_q != ST_IDLE);

  always_comb begin
    high_inc  = (high_q == SAT) ? SAT : high_q + 1'b1;
    sum_inc   = {1'b0, low_q} + {1'b0, high_inc};
    st_d      = st_q;
    low_d     = low_q;
    high_d    = high_q;
    push_o    = 1'b0;
    timeout_o = 1'b0;
    word_o    = '{high: high_q, low: low_q};
    if (!run_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (fall) begin
          st_d   = ST_LOW;
          low_d  = '0;
          high_d = '0;
        end
        ST_LOW: begin
          if (rise) begin
            st_d   = ST_HIGH;
            high_d = '0;
          end else if (tick_i && low_q != SAT) begin
            low_d = low_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (fall) begin
            push_o = 1'b1;
            st_d   = ST_LOW;
            low_d  = '0;
            high_d = '0;
          end else if (tick_i) begin
            high_d = high_inc;
            if (sum_inc >= {1'b0, max_w_i}) begin
              push_o    = 1'b1;
              timeout_o = 1'b1;
              word_o    = '{high: high_inc, low: low_q};
              st_d      = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      low_q  <= '0;
      high_q <= '0;
    end else begin
      st_q   <= st_d;
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

  p_timeout_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> (st_q == ST_IDLE));
  p_timeout_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && high_q != SAT) |->
      ({1'b0, word_o.low} + {1'b0, word_o.high} == {1'b0, max_w_i}));
endmodule

// File: rtl/irc_sym_fifo.sv
module irc_sym_fifo
  import irc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  sym_t                       wdata_i,
  input  logic                       pop_i,
  output sym_t                       rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  sym_t             mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = empty_o ? '0 : mem[rp_q];
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      count_q <= count_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  p_full_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (count_q == $past(count_q)));
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/irc_capture.sv
module irc_capture
  import irc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]       rs_q;
  logic             rst_s;
  logic [3:0]       widx;
  logic             en_q, en_d, run_q, run_d;
  logic [31:0]      cfg_q, cfg_d;
  logic [2:0]       mask_q, mask_d, st_q, st_d, st_vis;
  logic             tick, restart, push, timeout, busy, pop;
  logic             full, empty;
  sym_t             in_word, head;
  logic [CNT_W-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];
  assign widx  = reg_addr[5:2];
  assign pop   = reg_rd && (widx == A_DATA);

  irc_unit_timer #(.DIV_W(7), .SUB_UNITS(10)) u_timer (
    .clk(clk), .rst_n(rst_s), .restart_i(restart), .div_i(cfg_q[6:0]),
    .tick_o(tick));

  irc_edge_meas #(.WID_W(16)) u_meas (
    .clk(clk), .rst_n(rst_s), .ir_i(ir_in), .run_i(run_q), .tick_i(tick),
    .max_w_i(cfg_q[31:16]), .restart_o(restart), .push_o(push),
    .word_o(in_word), .timeout_o(timeout), .busy_o(busy));

  irc_sym_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .push_i(push), .wdata_i(in_word), .pop_i(pop),
    .rdata_o(head), .count_o(fill), .full_o(full), .empty_o(empty));

  always_comb begin
    en_d   = en_q;
    run_d  = run_q;
    cfg_d  = cfg_q;
    mask_d = mask_q;
    st_d   = st_q;
    if (reg_wr) begin
      case (widx)
        A_ENABLE: begin
          en_d = reg_wdata[0];
          if (!reg_wdata[0]) run_d = 1'b0;
        end
        A_GO:   if (en_q) run_d = 1'b1;
        A_CFG:  cfg_d = reg_wdata;
        A_MASK: mask_d = reg_wdata[10:8];
        A_CLR:  st_d = st_q & ~reg_wdata[18:16];
        default: ;
      endcase
    end
    if ({26'd0, fill} >= {1'b0, cfg_q[13:8]} + 7'd1) st_d[0] = 1'b1;
    if (timeout)       st_d[1] = 1'b1;
    if (push && full)  st_d[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      cfg_q  <= CFG_RESET;
      mask_q <= '0;
      st_q   <= '0;
    end else begin
      en_q   <= en_d;
      run_q  <= run_d;
      cfg_q  <= cfg_d;
      mask_q <= mask_d;
      st_q   <= st_d;
    end
  end

  assign st_vis = st_q & ~mask_q;
  assign irq_o  = |st_vis;

  always_comb begin
    reg_rdata = '0;
    case (widx)
      A_ENABLE: reg_rdata = {31'd0, en_q};
      A_BUSY:   reg_rdata = {31'd0, busy};
      A_CFG:    reg_rdata = cfg_q;
      A_MASK:   reg_rdata = {21'd0, mask_q, 8'd0};
      A_STAT:   reg_rdata = {5'd0, st_vis, 13'd0, st_q, 8'd0};
      A_FILL:   reg_rdata = {{(32-CNT_W){1'b0}}, fill};
      A_DATA:   reg_rdata = head;
      default:  reg_rdata = '0;
    endcase
  end

  p_ovf_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(st_q[2]) |-> $past(full));
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (mask_q == 3'b111) |-> !irq_o);
  p_clear_ovf_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_wr && widx == A_CLR && reg_wdata[18] && !(push && full)) |=> !st_q[2]);
  p_no_capture_idle_r3: assert property (@(posedge clk) disable iff (!rst_s)
    !run_q |-> !push);
endmodule

// File: tb/irc_capture_tb_top.sv
module irc_capture_tb_top;
  localparam int P    = 10;
  localparam int MAXW = 40;
  localparam int NV   = 6;
  localparam int VLOW [NV] = '{3, 1, 7, 2, 5, 4};
  localparam int VHIGH[NV] = '{2, 6, 1, 3, 4, 0};
  localparam int VEXPH[NV] = '{2, 6, 1, 3, 4, 36};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_in;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_o;
  int          n_chk = 0, n_bad = 0;
  int          lo[32], hi[32];

  always #10 clk = ~clk;

  irc_capture #(.DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #5 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) begin
      ir_in = 1'b0;
      repeat (lo[i] * P + 5) @(negedge clk);
      ir_in = 1'b1;
      if (i < n - 1) repeat (hi[i] * P + 5) @(negedge clk);
      else           repeat ((MAXW - lo[i]) * P + 40) @(negedge clk);
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cfgv;
    rst_n = 1'b0; ir_in = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(6'h0C, v); check("R1 cfg", v, 32'h3E80_0080);
    rd(6'h1C, v); check("R1 fill", v, 0);
    rd(6'h14, v); check("R1 stat", v, 0);
    check("R1 irq", {31'd0, irq_o}, 0);

    cfgv = (MAXW << 16) | 32'h0000_4080;
    wr(6'h0C, cfgv);
    rd(6'h0C, v); check("R2 cfg readback", v, cfgv);
    cfgv = (MAXW << 16) | 32'h0000_0080;
    wr(6'h0C, cfgv);

    wr(6'h00, 1);
    lo[0] = 2; hi[0] = 0; frame(1);
    rd(6'h1C, v); check("R3 no capture before start", v, 0);
    wr(6'h04, 1);

    for (int i = 0; i < NV; i++) begin lo[i] = VLOW[i]; hi[i] = VHIGH[i]; end
    frame(NV);
    rd(6'h1C, v); check("R6 fill after frame", v, NV);
    rd(6'h14, v); check("R5 R7 R10 stat", v, 32'h0300_0300);
    check("R10 irq high", {31'd0, irq_o}, 1);
    for (int i = 0; i < NV; i++) begin
      rd(6'h20, v);
      check(i == NV - 1 ? "R5 timeout word" : "R4 word", v,
            (32'(VEXPH[i]) << 16) | 32'(VLOW[i]));
    end
    rd(6'h20, v); check("R6 empty read", v, 0);
    rd(6'h1C, v); check("R6 fill empty", v, 0);
    wr(6'h18, 32'h0007_0000);
    rd(6'h14, v); check("R9 cleared", v, 0);
    check("R9 irq low", {31'd0, irq_o}, 0);

    wr(6'h0C, cfgv | 32'h0000_0400);
    lo[0] = 2; hi[0] = 2; lo[1] = 3; hi[1] = 1; lo[2] = 1;
    frame(3);
    rd(6'h14, v); check("R7 below level", {31'd0, v[8]}, 0);
    frame(3);
    rd(6'h14, v); check("R7 at level", {31'd0, v[8]}, 1);
    wr(6'h10, 32'h0000_0700);
    rd(6'h14, v); check("R10 masked mirror", v, 32'h0000_0300);
    check("R10 masked irq", {31'd0, irq_o}, 0);
    wr(6'h10, 0);
    for (int i = 0; i < 6; i++) rd(6'h20, v);
    wr(6'h0C, cfgv);
    wr(6'h18, 32'h0007_0000);

    for (int i = 0; i < 18; i++) begin lo[i] = (i % 5) + 1; hi[i] = 2; end
    frame(18);
    rd(6'h1C, v); check("R8 fill at depth", v, 16);
    rd(6'h14, v); check("R8 overflow flag", {31'd0, v[10]}, 1);
    rd(6'h20, v); check("R8 oldest kept", v, 32'h0002_0001);
    wr(6'h18, 32'h0004_0000);
    rd(6'h14, v); check("R9 overflow cleared", {31'd0, v[10]}, 0);
    for (int i = 0; i < 15; i++) rd(6'h20, v);
    wr(6'h18, 32'h0007_0000);

    ir_in = 1'b0;
    repeat (20) @(negedge clk);
    rd(6'h08, v); check("R11 busy in symbol", v, 1);
    ir_in = 1'b1;
    repeat (MAXW * P + 40) @(negedge clk);
    rd(6'h08, v); check("R11 idle", v, 0);
    rd(6'h20, v);
    wr(6'h00, 0);
    lo[0] = 2; hi[0] = 0; frame(1);
    rd(6'h1C, v); check("R3 stopped by enable", v, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule